// File: doc/BRIEF.md
# Nibble-Wide DRAM Byte Sequencer

This block sequences a dynamic RAM whose data bus is four bits wide, so that it delivers whole bytes to two clients. It runs on a fast tick clock and divides time into access slots of eight ticks. In an active slot it opens one row and then issues two column strobes on that row. The first strobe moves the low half of the byte and the second moves the high half. Read halves are joined into one byte. Write bytes are split into two halves.

Slots alternate between two owners. An even slot belongs to the video fetch port. An odd slot belongs to the processor port. The block drives a processor clock, `phi_out`, that is low through every even slot and high through every odd slot. The processor address is latched partway through the even slot, which runs alongside the video access. Write data is latched early in the odd slot, and the processor access is completed in that odd slot. A slot whose owner has not asked for an access leaves every strobe inactive.

With the default parameters the row and column fields are each eight bits wide on the multiplexed address pins. A byte address therefore has `2*MA_W-1` bits. The upper `MA_W` bits form the row. The lower `MA_W-1` bits, followed by a half-select bit, form the column.

Top module: `nibble_dram_seq`

## Requirements
- R1: Ticks within a slot are numbered 0 to 7, and tick 0 of the first slot after reset is even. In an active slot `ras_n` is high on ticks 0 and 1 and low on ticks 2 to 7. In an idle slot `ras_n`, `cas_n` and `we_n` all stay high.
- R2: In an active slot `cas_n` is low on ticks 3, 4, 6 and 7 and high on ticks 0, 1, 2 and 5, so each row strobe carries exactly two column strobes.
- R3: For slot address `a`, `ma` shows `a[2*MA_W-2:MA_W-1]` on ticks 0 to 2. It shows `{a[MA_W-2:0],1'b0}` on ticks 3 to 5 and `{a[MA_W-2:0],1'b1}` on ticks 6 and 7.
- R4: A read byte takes its low nibble from `dq_i` at the clock edge that ends tick 4, and its high nibble from `dq_i` at the edge that ends tick 7.
- R5: `phi_out` is low throughout even slots and high throughout odd slots, and it is low in reset.
- R6: `vid_req` and `vid_addr` are sampled at the edge that ends an odd slot, and the access is made in the next even slot. After a video read, `vid_ready` is high for the single tick 0 of the following odd slot, and `vid_rdata` holds the byte at that time.
- R7: `cpu_sel`, `cpu_rnw` (1 = read) and `cpu_addr` are sampled at the edge that ends tick 5 of an even slot, and the access is made in the next odd slot. After a read, `cpu_ready` is high for the single tick 0 of the next even slot, and `cpu_rdata` holds the byte at that time.
- R8: In a processor write slot, `cpu_wdata` is sampled at the edge that ends tick 2. `we_n` is low on ticks 2 to 7. `dq_oe` is high on ticks 3 to 7, with `dq_o` equal to `wdata[3:0]` on ticks 3 to 5 and `wdata[7:4]` on ticks 6 and 7. A write raises no `cpu_ready`.
- R9: While `rst_n` is low, `ras_n`, `cas_n` and `we_n` are high, and `dq_oe`, `vid_ready` and `cpu_ready` are low.
- R10: The strobes keep minimum widths. `ras_n` stays low for at least 3 ticks and high for at least 2 ticks. Each `cas_n` low pulse lasts at least 2 ticks. `we_n` never changes while `cas_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock (one slot = 8 ticks) |
| rst_n | input | 1 | Active-low synchronous reset |
| vid_req | input | 1 | Video wants a byte in the next even slot |
| vid_addr | input | 2*MA_W-1 | Video byte address |
| vid_ready | output | 1 | One-tick pulse: video byte available |
| vid_rdata | output | 2*NIB_W | Video read byte |
| cpu_sel | input | 1 | Processor access targets this RAM |
| cpu_rnw | input | 1 | 1 = read, 0 = write |
| cpu_addr | input | 2*MA_W-1 | Processor byte address |
| cpu_wdata | input | 2*NIB_W | Processor write byte |
| cpu_ready | output | 1 | One-tick pulse: processor read byte available |
| cpu_rdata | output | 2*NIB_W | Processor read byte |
| phi_out | output | 1 | Processor clock, half the slot rate |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ma | output | MA_W | Multiplexed row/column address |
| dq_o | output | NIB_W | Write nibble to the RAM |
| dq_oe | output | 1 | Drive enable for `dq_o` |
| dq_i | input | NIB_W | Read nibble from the RAM |

## Verification
The bench builds the block with its defaults, `MA_W = 8` and `NIB_W = 4`, which give a 15-bit byte address. Both the all-zero and all-ones byte addresses are reachable, so the extreme row and column values appear on `ma`. A behavioural nibble memory in the bench responds to the strobes. Bytes written through the processor port are later read back through both ports, which shows that the half order and the address split agree end to end. The pattern mixes idle, read-only and write slots, so strobe suppression, write-enable timing and the ready pulses are all compared against a tick-counting model on every clock.

// File: rtl/nibble_dram_seq_pkg.sv
package nibble_dram_seq_pkg;

  localparam int TICK_W = 3;

  // Tick schedule inside one eight-tick slot
  localparam logic [TICK_W-1:0] T_RAS_FALL = 3'd2;
  localparam logic [TICK_W-1:0] T_CAS1_FALL = 3'd3;
  localparam logic [TICK_W-1:0] T_CAS1_LAST = 3'd4;
  localparam logic [TICK_W-1:0] T_CAS_GAP = 3'd5;
  localparam logic [TICK_W-1:0] T_CAS2_FALL = 3'd6;
  localparam logic [TICK_W-1:0] T_LAST = 3'd7;
  localparam logic [TICK_W-1:0] T_CPU_ADDR = 3'd5;
  localparam logic [TICK_W-1:0] T_CPU_DATA = 3'd2;

  typedef enum logic [1:0] {
    PH_ROW    = 2'd0,
    PH_COL_LO = 2'd1,
    PH_COL_HI = 2'd2
  } addr_phase_e;

  // Row strobe active from its falling tick to the end of the slot
  function automatic logic ras_active(input logic [TICK_W-1:0] t);
    return t >= T_RAS_FALL;
  endfunction

  // Two column strobes separated by a single precharge tick
  function automatic logic cas_active(input logic [TICK_W-1:0] t);
    return ((t >= T_CAS1_FALL) && (t <= T_CAS1_LAST)) || (t >= T_CAS2_FALL);
  endfunction

  // Which address field the multiplexer presents on a given tick
  function automatic addr_phase_e phase_of(input logic [TICK_W-1:0] t);
    if (t < T_CAS1_FALL) return PH_ROW;
    if (t < T_CAS2_FALL) return PH_COL_LO;
    return PH_COL_HI;
  endfunction

endpackage

// File: rtl/nsq_slot_timer.sv
module nsq_slot_timer
  import nibble_dram_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  output logic [TICK_W-1:0] tick,
  output logic              odd_slot,
  output logic              slot_last
);

  logic [TICK_W-1:0] tick_q;
  logic              odd_q;

  assign slot_last = (tick_q == T_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_q <= '0;
      odd_q  <= 1'b0;
    end else begin
      tick_q <= tick_q + 1'b1;
      if (slot_last) odd_q <= ~odd_q;
    end
  end

  assign tick     = tick_q;
  assign odd_slot = odd_q;

endmodule

// File: rtl/nsq_port_capture.sv
module nsq_port_capture
  import nibble_dram_seq_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TICK_W-1:0] tick,
  input  logic              odd_slot,
  input  logic              vid_req,
  input  logic [ADDR_W-1:0] vid_addr,
  input  logic              cpu_sel,
  input  logic              cpu_rnw,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [BYTE_W-1:0] cpu_wdata,
  output logic              v_act,
  output logic [ADDR_W-1:0] v_addr,
  output logic              c_act,
  output logic              c_rnw,
  output logic [ADDR_W-1:0] c_addr,
  output logic [BYTE_W-1:0] c_wdata
);

  logic take_vid, take_cpu, take_wd;

  assign take_vid = odd_slot && (tick == T_LAST);
  assign take_cpu = !odd_slot && (tick == T_CPU_ADDR);
  assign take_wd  = odd_slot && (tick == T_CPU_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_act   <= 1'b0;
      v_addr  <= '0;
      c_act   <= 1'b0;
      c_rnw   <= 1'b1;
      c_addr  <= '0;
      c_wdata <= '0;
    end else begin
      if (take_vid) begin
        v_act  <= vid_req;
        v_addr <= vid_addr;
      end
      if (take_cpu) begin
        c_act  <= cpu_sel;
        c_rnw  <= cpu_rnw;
        c_addr <= cpu_addr;
      end
      if (take_wd) c_wdata <= cpu_wdata;
    end
  end

endmodule

// File: rtl/nsq_strobe_gen.sv
module nsq_strobe_gen
  import nibble_dram_seq_pkg::*;
(
  input  logic              rst_n,
  input  logic [TICK_W-1:0] tick,
  input  logic              active,
  input  logic              write,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              drive,
  output addr_phase_e       phase
);

  logic run;

  assign run   = rst_n && active;
  assign phase = phase_of(tick);

  always_comb begin
    ras_n = !(run && ras_active(tick));
    cas_n = !(run && cas_active(tick));
    we_n  = !(run && write && ras_active(tick));
    drive = run && write && (tick >= T_CAS1_FALL);
  end

endmodule

// File: rtl/nsq_read_assembler.sv
module nsq_read_assembler
  import nibble_dram_seq_pkg::*;
#(
  parameter int NIB_W = 4,
  localparam int BYTE_W = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TICK_W-1:0] tick,
  input  logic              odd_slot,
  input  logic              active,
  input  logic              is_read,
  input  logic [NIB_W-1:0]  dq_i,
  output logic              vid_ready,
  output logic [BYTE_W-1:0] vid_rdata,
  output logic              cpu_ready,
  output logic [BYTE_W-1:0] cpu_rdata
);

  logic [NIB_W-1:0]  lo_q;
  logic              take_lo, done;
  logic [BYTE_W-1:0] joined;

  assign take_lo = active && (tick == T_CAS1_LAST);
  assign done    = active && is_read && (tick == T_LAST);
  assign joined  = {dq_i, lo_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q      <= '0;
      vid_ready <= 1'b0;
      cpu_ready <= 1'b0;
      vid_rdata <= '0;
      cpu_rdata <= '0;
    end else begin
      if (take_lo) lo_q <= dq_i;
      vid_ready <= done && !odd_slot;
      cpu_ready <= done && odd_slot;
      if (done && !odd_slot) vid_rdata <= joined;
      if (done && odd_slot)  cpu_rdata <= joined;
    end
  end

endmodule

// File: rtl/nibble_dram_seq.sv
module nibble_dram_seq
  import nibble_dram_seq_pkg::*;
#(
  parameter int MA_W  = 8,
  parameter int NIB_W = 4,
  localparam int ADDR_W = 2 * MA_W - 1,
  localparam int BYTE_W = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vid_req,
  input  logic [ADDR_W-1:0] vid_addr,
  output logic              vid_ready,
  output logic [BYTE_W-1:0] vid_rdata,
  input  logic              cpu_sel,
  input  logic              cpu_rnw,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [BYTE_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [BYTE_W-1:0] cpu_rdata,
  output logic              phi_out,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [MA_W-1:0]   ma,
  output logic [NIB_W-1:0]  dq_o,
  output logic              dq_oe,
  input  logic [NIB_W-1:0]  dq_i
);

  logic [TICK_W-1:0] tick;
  logic              odd_slot, slot_last;
  logic              v_act, c_act, c_rnw;
  logic [ADDR_W-1:0] v_addr, c_addr, slot_addr;
  logic [BYTE_W-1:0] c_wdata;
  logic              slot_active, slot_write;
  addr_phase_e       phase;

  nsq_slot_timer u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .odd_slot(odd_slot), .slot_last(slot_last)
  );

  nsq_port_capture #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_capture (
    .clk(clk), .rst_n(rst_n), .tick(tick), .odd_slot(odd_slot),
    .vid_req(vid_req), .vid_addr(vid_addr),
    .cpu_sel(cpu_sel), .cpu_rnw(cpu_rnw), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata),
    .v_act(v_act), .v_addr(v_addr), .c_act(c_act), .c_rnw(c_rnw),
    .c_addr(c_addr), .c_wdata(c_wdata)
  );

  // Slot ownership: video in even slots, processor in odd slots
  assign slot_active = odd_slot ? c_act : v_act;
  assign slot_addr   = odd_slot ? c_addr : v_addr;
  assign slot_write  = odd_slot && !c_rnw;

  nsq_strobe_gen u_strobe (
    .rst_n(rst_n), .tick(tick), .active(slot_active), .write(slot_write),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .drive(dq_oe), .phase(phase)
  );

  // Row field is the upper half of the byte address; the column field is
  // the lower bits followed by the nibble select.
  always_comb begin
    unique case (phase)
      PH_ROW:    ma = slot_addr[ADDR_W-1 -: MA_W];
      PH_COL_LO: ma = {slot_addr[MA_W-2:0], 1'b0};
      default:   ma = {slot_addr[MA_W-2:0], 1'b1};
    endcase
  end

  assign dq_o = !dq_oe ? '0 :
                (phase == PH_COL_HI) ? c_wdata[BYTE_W-1:NIB_W] : c_wdata[NIB_W-1:0];

  assign phi_out = odd_slot;

  nsq_read_assembler #(.NIB_W(NIB_W)) u_assemble (
    .clk(clk), .rst_n(rst_n), .tick(tick), .odd_slot(odd_slot),
    .active(slot_active), .is_read(!slot_write), .dq_i(dq_i),
    .vid_ready(vid_ready), .vid_rdata(vid_rdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata)
  );

endmodule

// File: rtl/nibble_dram_seq_checker.sv
module nibble_dram_seq_checker (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic phi_out,
  input logic vid_ready,
  input logic cpu_ready
);

  logic       ras_prev, cas_prev;
  logic [1:0] cas_falls;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_prev  <= 1'b1;
      cas_prev  <= 1'b1;
      cas_falls <= '0;
    end else begin
      ras_prev <= ras_n;
      cas_prev <= cas_n;
      if (ras_prev && !ras_n) cas_falls <= '0;
      else if (cas_prev && !cas_n && cas_falls != 2'd3) cas_falls <= cas_falls + 1'b1;
    end
  end

  assert_two_cas_per_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_prev && ras_n) |-> (cas_falls == 2'd2));

  assert_ras_low_min_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |=> !ras_n ##1 !ras_n);

  assert_ras_high_min_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |=> ras_n);

  assert_cas_low_min_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |=> !cas_n);

  assert_cas_inside_ras_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);

  assert_we_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> $stable(we_n));

  assert_ready_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vid_ready, cpu_ready}));

  assert_vid_ready_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vid_ready |-> phi_out ##1 !vid_ready);

  assert_cpu_ready_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !phi_out ##1 !cpu_ready);

endmodule

bind nibble_dram_seq nibble_dram_seq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .phi_out(phi_out), .vid_ready(vid_ready), .cpu_ready(cpu_ready)
);

// File: tb/nibble_dram_seq_bench.sv
module nibble_dram_seq_bench;

  localparam int MA_W = 8;
  localparam int NIB_W = 4;
  localparam int AW = 2 * MA_W - 1;
  localparam int BW = 2 * NIB_W;
  localparam int PAIRS = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vid_req = 1'b0;
  logic [AW-1:0] vid_addr = '0;
  logic vid_ready;
  logic [BW-1:0] vid_rdata;
  logic cpu_sel = 1'b0, cpu_rnw = 1'b1;
  logic [AW-1:0] cpu_addr = '0;
  logic [BW-1:0] cpu_wdata = '0;
  logic cpu_ready;
  logic [BW-1:0] cpu_rdata;
  logic phi_out, ras_n, cas_n, we_n, dq_oe;
  logic [MA_W-1:0] ma;
  logic [NIB_W-1:0] dq_o;
  logic [NIB_W-1:0] dq_i = '0;

  always #10 clk = ~clk;

  nibble_dram_seq #(.MA_W(MA_W), .NIB_W(NIB_W)) u_nibble_dram_seq (
    .clk(clk), .rst_n(rst_n), .vid_req(vid_req), .vid_addr(vid_addr),
    .vid_ready(vid_ready), .vid_rdata(vid_rdata), .cpu_sel(cpu_sel),
    .cpu_rnw(cpu_rnw), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .phi_out(phi_out),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ma(ma), .dq_o(dq_o),
    .dq_oe(dq_oe), .dq_i(dq_i)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Initial nibble contents of the bench memory, keyed by 2*byte_addr+half
  function automatic logic [NIB_W-1:0] seed(input int key);
    return NIB_W'(key * 7 + 3);
  endfunction

  logic [NIB_W-1:0] dmem [int];
  logic [BW-1:0]    ref_mem [int];

  function automatic logic [BW-1:0] ref_byte(input int a);
    if (ref_mem.exists(a)) return ref_mem[a];
    return {seed(2 * a + 1), seed(2 * a)};
  endfunction

  function automatic logic [AW-1:0] wr_addr(input int j);
    if (j == 0) return '0;
    if (j == 1) return '1;
    return AW'(j * 1237);
  endfunction

  // Reference model state
  int cyc = 0;
  bit m_vact = 0, m_cact = 0, m_crnw = 1;
  int m_vaddr = 0, m_caddr = 0;
  logic [BW-1:0] m_cwd = '0;
  bit exp_vr = 0, exp_cr = 0;
  logic [BW-1:0] exp_vd = '0, exp_cd = '0;

  always @(posedge clk) begin
    if (rst_n) begin
      int tk, od;
      tk = cyc % 8;
      od = (cyc / 8) % 2;
      exp_vr = (tk == 7) && (od == 0) && m_vact;
      exp_cr = (tk == 7) && (od == 1) && m_cact && m_crnw;
      if (exp_vr) exp_vd = ref_byte(m_vaddr);
      if (exp_cr) exp_cd = ref_byte(m_caddr);
      if (tk == 7 && od == 1 && m_cact && !m_crnw) ref_mem[m_caddr] = m_cwd;
      if (tk == 7 && od == 1) begin m_vact = vid_req; m_vaddr = int'(vid_addr); end
      if (tk == 5 && od == 0) begin
        m_cact = cpu_sel; m_crnw = cpu_rnw; m_caddr = int'(cpu_addr);
      end
      if (tk == 2 && od == 1) m_cwd = cpu_wdata;
      cyc++;
    end
  end

  task automatic drive_pair(input int k);
    vid_req  = (k % 5) != 4;
    vid_addr = (k >= 12) ? wr_addr(k % 10) : AW'(k * 401);
    cpu_sel  = !(k >= 20 && k < 30);
    cpu_rnw  = (k >= 10);
    cpu_addr = (k < 20) ? wr_addr(k % 10) : AW'(k * 911);
    cpu_wdata = BW'(k * 29 + 5);
  endtask

  // Bench memory, per-clock comparison and stimulus, all away from posedge
  logic ras_d = 1'b1, cas_d = 1'b1;
  int row_l = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(ras_n && cas_n && we_n, "R9 strobes idle in reset", {ras_n, cas_n, we_n}, 7);
      chk(!dq_oe && !vid_ready && !cpu_ready, "R9 outputs quiet in reset",
          {dq_oe, vid_ready, cpu_ready}, 0);
      chk(!phi_out, "R5 phi low in reset", phi_out, 0);
    end else begin
      int tk, od, a;
      bit act, wr;
      logic [MA_W-1:0] ema;
      tk  = cyc % 8;
      od  = (cyc / 8) % 2;
      act = od ? m_cact : m_vact;
      a   = od ? m_caddr : m_vaddr;
      wr  = od && m_cact && !m_crnw;
      chk(ras_n == !(act && tk >= 2), "R1 ras_n", ras_n, !(act && tk >= 2));
      chk(cas_n == !(act && (tk == 3 || tk == 4 || tk >= 6)), "R2 cas_n", cas_n,
          !(act && (tk == 3 || tk == 4 || tk >= 6)));
      chk(we_n == !(wr && tk >= 2), "R8 we_n", we_n, !(wr && tk >= 2));
      chk(phi_out == od[0], "R5 phi_out", phi_out, od);
      chk(dq_oe == (wr && tk >= 3), "R8 dq_oe", dq_oe, wr && tk >= 3);
      if (wr && tk >= 3) begin
        logic [NIB_W-1:0] en;
        en = (tk >= 6) ? m_cwd[BW-1:NIB_W] : m_cwd[NIB_W-1:0];
        chk(dq_o == en, "R8 dq_o nibble", dq_o, en);
      end
      if (act) begin
        if (tk <= 2) ema = MA_W'(a >> (MA_W - 1));
        else ema = MA_W'(((a % (1 << (MA_W - 1))) * 2) + (tk >= 6 ? 1 : 0));
        chk(ma == ema, "R3 ma", ma, ema);
      end
      chk(vid_ready == exp_vr, "R6 vid_ready", vid_ready, exp_vr);
      chk(cpu_ready == exp_cr, "R7 cpu_ready", cpu_ready, exp_cr);
      if (exp_vr) chk(vid_rdata == exp_vd, "R4 R6 vid_rdata", vid_rdata, exp_vd);
      if (exp_cr) chk(cpu_rdata == exp_cd, "R4 R7 cpu_rdata", cpu_rdata, exp_cd);
      if (cyc % 16 == 0) drive_pair(cyc / 16);
    end
    // Nibble memory reacting to the strobes
    if (ras_d && !ras_n) row_l = int'(ma);
    if (cas_d && !cas_n) begin
      int key;
      key = row_l * (1 << MA_W) + int'(ma);
      if (!we_n) dmem[key] = dq_o;
      dq_i = dmem.exists(key) ? dmem[key] : seed(key);
    end
    ras_d = ras_n;
    cas_d = cas_n;
  end

  initial begin
    drive_pair(0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (PAIRS * 16 + 40) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule